// File: doc/BRIEF.md
# Fourteen-Channel PWM DAC Bank

This block turns fourteen 8-bit duty values into pulse-width modulated waveforms. A single free-running 8-bit counter, advanced on every system clock, is shared by all channels. Every PWM period is therefore 256 clocks long, and every channel begins its period on the same edge. Each channel compares the counter against its active duty value. The output is high while the counter is below that value.

Software reaches the block through a small write strobe/address/data interface, and the register addressed at the moment can be read back on a combinational read bus. Each duty value is written into a shadow register. It moves into the active comparator only when the counter wraps, so a period is never cut short or stretched by a write.

Channels 0 to 7 drive dedicated outputs. Channels 8 to 13 share six pins with general-purpose port bits. An active-low select register decides, pin by pin, whether the pin carries the PWM waveform or the port data latch value supplied from outside.

Top module: `pwm_dac_bank`

## Requirements
- R1: One 8-bit counter, reset to 0 and incremented on every clock, serves all channels. A period is 256 clocks long, and every channel's high phase starts at counter value 0.
- R2: A channel output is high while the counter is less than the channel's active duty value and low otherwise. An active duty of 00h keeps the output low for the whole period.
- R3: An active duty of N gives exactly N high clocks per 256-clock period, as one contiguous run. A duty of FFh gives 255 high clocks.
- R4: Duty registers for channels 0 to 13 sit at addresses 0 to 13. Each resets to 80h, and a read at its address returns the value most recently written to it.
- R5: A duty write reaches the output only at the next counter wrap (255 to 0). A write captured on the wrap edge itself is used for the period that begins there. The active duty never changes mid-period.
- R6: The pin-select register sits at address 14, and its bits 5:0 map to shared pins 0 to 5. A bit value of 0 routes channel 8+k to shared pin k. A bit value of 1 routes port_data[k] to that pin. The register resets to 3Fh, write bits 7:6 are discarded, and a read returns {2'b00, select}.
- R7: After reset, dedicated channels run at 50% duty (128 high clocks per period), and every shared pin follows port_data.
- R8: Writes to addresses 15 to 31 change no register, and reads at those addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one counter step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| addr | input | 5 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr (combinational) |
| port_data | input | 6 | Port data latch values for the six shared pins |
| pwm_ded | output | 8 | Waveforms of channels 0 to 7 |
| pwm_shared | output | 6 | Shared pins: channel 8+k or port_data[k] |

## Verification
The bench measures the number and position of high clocks in whole periods for extreme duty values (00h, 01h, FFh) as well as mid-range ones. An off-by-one comparator would show 1 or 256 high clocks where none or 255 are expected. A channel that is not phase-aligned would start its high run away from count 0. A write issued mid-period must leave that period at its old length, and a write on the wrap edge must take effect at once. A design without the shadow register would produce a truncated or stretched period, and a design that drops the wrap-edge write would lag a full period. Pin-select polarity, discarded upper select bits and writes to unmapped addresses are each checked through the pins and the read bus. An inverted select, or a decoder that aliases addresses, would show up there.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants and types for the PWM DAC bank.
// Assumes an 8-bit duty resolution throughout the bank.
package pwm_bank_pkg;
    localparam int DUTY_W = 8;
    typedef logic [DUTY_W-1:0] duty_t;
    localparam duty_t DUTY_MID = duty_t'(1 << (DUTY_W - 1));
endpackage

// File: rtl/pwm_timebase.sv
// Module: shared free-running period counter.
// Steps once per clock and flags the last count of each period.
// Assumes a synchronous active-low reset that holds the count at zero.
module pwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // Advance the period counter; it rolls over naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Last count of the period: the next edge starts a new period.
    assign wrap = (cnt == {CNT_W{1'b1}});

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + 1'b1)); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == {CNT_W{1'b1}}) |=> (cnt == '0)); // R1
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel with a shadow duty register.
// The written value waits in the shadow register and moves into the active
// register at the period wrap. A write on the wrap edge is forwarded.
// Assumes cnt and wrap come from the shared pwm_timebase.
module pwm_channel #(
    parameter int                 CNT_W   = 8,
    parameter logic [CNT_W-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] duty_q,
    output logic             pwm
);
    logic [CNT_W-1:0] act;

    // Shadow register: holds the most recently written duty value.
    always_ff @(posedge clk) begin
        if (!rst_n)  duty_q <= RST_VAL;
        else if (wr) duty_q <= wdata;
    end

    // Active register: reloads only at the wrap, forwarding a same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= RST_VAL;
        else if (wrap) act <= wr ? wdata : duty_q;
    end

    // Comparator: high while the counter is below the active duty.
    assign pwm = (cnt < act);

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act)); // R5
    AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr) |=> (act == $past(duty_q))); // R5
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> (cnt == '0)); // R1
endmodule

// File: rtl/pwm_pin_mux.sv
// Module: per-pin selection between PWM waveform and port data.
// An active-low select bit of 0 hands the pin to the PWM channel.
// Assumes a purely combinational path; the pad registers it if needed.
module pwm_pin_mux #(
    parameter int N_PIN = 6
) (
    input  logic [N_PIN-1:0] sel_n,
    input  logic [N_PIN-1:0] pwm,
    input  logic [N_PIN-1:0] port,
    output logic [N_PIN-1:0] pin
);
    for (genvar k = 0; k < N_PIN; k++) begin : g_pin
        // Select the pin's source per its own select bit.
        assign pin[k] = sel_n[k] ? port[k] : pwm[k];
    end
endmodule

// File: rtl/pwm_dac_bank.sv
// Module: top of the PWM DAC bank.
// Decodes register writes, drives the read bus, holds the pin-select register
// and instantiates the shared counter, the channels and the pin muxes.
// Assumes channel i duty lives at address i, and the select register sits
// right after the last channel.
module pwm_dac_bank
    import pwm_bank_pkg::*;
#(
    parameter int N_CH     = 14,
    parameter int N_SHARED = 6,
    parameter int ADDR_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DUTY_W-1:0]       wdata,
    output logic [DUTY_W-1:0]       rdata,
    input  logic [N_SHARED-1:0]     port_data,
    output logic [N_CH-N_SHARED-1:0] pwm_ded,
    output logic [N_SHARED-1:0]     pwm_shared
);
    localparam int               N_DED   = N_CH - N_SHARED;
    localparam logic [ADDR_W-1:0] SEL_ADR = ADDR_W'(N_CH);

    logic [DUTY_W-1:0]   cnt;
    logic                wrap;
    logic [N_CH-1:0]     pwm_all;
    logic [N_CH-1:0]     wr_ch;
    duty_t               duty_q [N_CH];
    logic [N_SHARED-1:0] sel_n;

    pwm_timebase #(.CNT_W(DUTY_W)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Write strobe for channel i.
        assign wr_ch[i] = wr_en && (addr == ADDR_W'(i));

        pwm_channel #(.CNT_W(DUTY_W), .RST_VAL(DUTY_MID)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .wrap  (wrap),
            .wr    (wr_ch[i]),
            .wdata (wdata),
            .duty_q(duty_q[i]),
            .pwm   (pwm_all[i])
        );
    end

    // Pin-select register: resets to all ones so port data owns every pin.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sel_n <= '1;
        else if (wr_en && addr == SEL_ADR)  sel_n <= wdata[N_SHARED-1:0];
    end

    // Read bus: duty shadow, select register, or zero for unmapped addresses.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CH; i++)
            if (addr == ADDR_W'(i)) rdata = duty_q[i];
        if (addr == SEL_ADR) rdata = DUTY_W'(sel_n);
    end

    assign pwm_ded = pwm_all[N_DED-1:0];

    pwm_pin_mux #(.N_PIN(N_SHARED)) u_mux (
        .sel_n(sel_n),
        .pwm  (pwm_all[N_CH-1:N_DED]),
        .port (port_data),
        .pin  (pwm_shared)
    );

    for (genvar k = 0; k < N_SHARED; k++) begin : g_chk
        AST_PORT_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            sel_n[k] |-> (pwm_shared[k] == port_data[k])); // R6
        AST_PWM_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_n[k] |-> (pwm_shared[k] == pwm_all[N_DED+k])); // R6
    end
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > SEL_ADR) |=> $stable(sel_n)); // R8
endmodule

// File: tb/pwm_dac_bank_tb.sv
module pwm_dac_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] port_data = 6'b101010;
    logic [7:0] pwm_ded;
    logic [5:0] pwm_shared;

    int nchk = 0;
    int nfail = 0;
    int k = 0;

    // Vector table: {channel, duty, expected high clocks}
    localparam logic [19:0] VEC [6] = '{
        {4'd0, 8'h00, 8'd0},
        {4'd1, 8'hFF, 8'd255},
        {4'd2, 8'h01, 8'd1},
        {4'd7, 8'h40, 8'd64},
        {4'd3, 8'h80, 8'd128},
        {4'd5, 8'hC3, 8'd195}
    };

    pwm_dac_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .port_data(port_data), .pwm_ded(pwm_ded),
        .pwm_shared(pwm_shared)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench's own model of the period position: edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        return (sel < 8) ? pwm_ded[sel] : pwm_shared[sel-8];
    endfunction

    task automatic wr(input int a, input int d);
        addr = 5'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = 5'(a);
        #1 d = int'(rdata);
    endtask

    // Measure one full period from counter value 0; ends at count 255.
    task automatic measure(input int sel, output int highs, output int first);
        highs = 0; first = -1;
        @(negedge clk);
        while (k % 256 != 0) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            if (pick(sel)) begin
                if (first < 0) first = i;
                highs++;
            end
            if (i < 255) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int h, f, d, mism;
        repeat (4) @(negedge clk);
        // Reset-state read-back (R4, R6)
        for (int a = 0; a < 14; a++) begin
            rd(a, d); chk("R4 reset duty readback", d, 8'h80);
        end
        rd(14, d); chk("R6 reset select readback", d, 8'h3F);
        chk("R7 shared pins follow port in reset", int'(pwm_shared), int'(port_data));
        @(negedge clk);
        rst_n = 1'b1;
        // Reset duty 50% (R7)
        measure(0, h, f);
        chk("R7 reset 50% high clocks", h, 128);
        chk("R1 reset phase start", f, 0);

        // Vector loop (R1, R2, R3, R4)
        foreach (VEC[v]) begin
            int ch = int'(VEC[v][19:16]);
            int du = int'(VEC[v][15:8]);
            int ex = int'(VEC[v][7:0]);
            wr(ch, du);
            rd(ch, d); chk("R4 duty readback", d, du);
            measure(ch, h, f);
            chk((ex == 0) ? "R2 zero duty high clocks" : "R3 high clocks", h, ex);
            chk("R1 high run starts at count 0", f, (ex == 0) ? -1 : 0);
        end

        // Mid-period write holds until wrap (R5)
        @(negedge clk);
        while (k % 256 != 0) @(negedge clk);
        h = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_ded[4]) h++;
            if (i == 100) begin
                addr = 5'd4; wdata = 8'h10; wr_en = 1'b1;
            end
            if (i == 101) wr_en = 1'b0;
            if (i < 255) @(negedge clk);
        end
        chk("R5 period with mid write keeps old duty", h, 128);
        measure(4, h, f);
        chk("R5 new duty after wrap", h, 16);

        // Write on the wrap edge takes effect immediately (R5); we sit at count 255
        wr(6, 8'h20);
        h = 0;
        for (int i = 0; i < 255; i++) begin
            if (pwm_ded[6]) h++;
            @(negedge clk);
        end
        if (pwm_ded[6]) h++;
        chk("R5 wrap-edge write used at once", h, 32);

        // Shared pin handover (R6)
        wr(8, 8'h30);
        wr(14, 8'h3E);
        measure(8, h, f);
        chk("R6 channel 8 on shared pin 0", h, 48);
        mism = 0;
        for (int i = 0; i < 64; i++) begin
            port_data = 6'(i);
            #1 if (pwm_shared[5:1] != port_data[5:1]) mism++;
        end
        chk("R6 other shared pins follow port", mism, 0);
        port_data = 6'b000000;
        wr(14, 8'hFF);
        rd(14, d); chk("R6 select bits 7:6 discarded", d, 8'h3F);
        measure(8, h, f);
        chk("R6 port owns pin 0 again", h, 0);

        // Unmapped addresses (R8)
        wr(20, 8'h5A);
        wr(15, 8'h00);
        rd(20, d); chk("R8 unmapped read zero", d, 0);
        rd(15, d); chk("R8 unmapped read zero", d, 0);
        rd(14, d); chk("R8 select unchanged", d, 8'h3F);
        rd(4, d);  chk("R8 duty 4 unchanged", d, 8'h10);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule